// File: doc/BRIEF.md
# Test-and-Set Shared Lock Register

This block is a hardware semaphore that up to four host functions share. Each host function reaches it through its own access port: a read strobe, a write strobe, an address and write data. The block works out which function is asking from two bits of the access address, not from the data. A read of the shared word returns the stored 16-bit value together with the test-and-set flag as it stood before the read, and then leaves the flag set. The function that saw the flag clear holds it. Only that holder may rewrite the shared word or release the flag. Software uses this primitive to build a lock. By convention the stored word carries a lock state in bits [1:0] (RESET = 0, FREE = 1, BUSY = 2), the owner function in bits [3:2], implementation-specific state in bits [11:4] and per-function state in bits [15:12].

A small two-state machine (OPEN, HELD) tracks the flag and its holder. The transitions are:

- **CLAIM** (OPEN to HELD): a value read is granted.
- **STORE** (HELD to OPEN): the holder writes the shared word.
- **RELEASE** (HELD to OPEN): the holder writes 0 to the flag word.

In all other cases the machine stays where it is. Two side reads are available and change nothing: a busy probe, and a query that returns the caller's own function ID. A write that is not allowed is dropped and raises a sticky error flag.

Address bits [3:2] of each access select the word:

| Code | Word |
|------|------|
| 0 | Shared value |
| 1 | Busy probe |
| 2 | Function-ID query |
| 3 | Flag word |

Top module: `tas_lock_reg`

## Requirements
- R1: After reset the stored word is 0, the flag is clear (OPEN), the error flag is 0 and no response is valid; the first value read returns 0 with flag 0.
- R2: A read (rd high, wr low) on a port gives `acc_rvalid` for that port one cycle later. A value read (word code 0) returns the stored word and the flag as it was before the read. Every later value read sees flag 1 until the flag is released.
- R3: When several ports do value reads in the same cycle while the flag is clear, only the one whose function ID is lowest sees 0, and a tie goes to the lower port index. Every other reader sees 1.
- R4: The function ID is taken from address bits [26:25]. A function-ID query (code 2) returns it in `rdata[1:0]` with the other bits 0, and changes neither the word nor the flag.
- R5: A write of word code 0 by the holder, while the machine is HELD, stores the write data and clears the flag (STORE).
- R6: A write of word code 0 or code 3 from a function that does not hold the flag, including any such write while OPEN, leaves the word and the flag unchanged and sets the error flag. The error flag stays set until reset.
- R7: A write to code 3 with `wdata[0]` = 0 by the holder clears the flag (RELEASE). A write to code 3 with `wdata[0]` = 1 is ignored and raises no error.
- R8: A busy probe (code 2'b01) returns 1 in `rdata[0]` when the flag is held or when stored bits [1:0] equal BUSY (2), and 0 otherwise. It does not change the flag.
- R9: If the holder releases in the same cycle that another function does a value read, the reader sees 1 and the flag ends clear.
- R10: Every read response that is not a value read returns `acc_rtas` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_rd | input | NP | Read strobe, one per port |
| acc_wr | input | NP | Write strobe, one per port |
| acc_addr | input | NP*AW | Access address per port; [26:25] function ID, [3:2] word code |
| acc_wdata | input | NP*DW | Write data per port |
| acc_rvalid | output | NP | Read response valid, one cycle after the strobe |
| acc_rdata | output | NP*DW | Read data per port |
| acc_rtas | output | NP | Flag as seen by a value read; 1 for any other read |
| acc_err | output | 1 | Sticky flag for a write that was not allowed |

## Verification
Two things can land in the same cycle: the holder's RELEASE and a value read from another function. Two more can also coincide: value reads from several functions at once. The bench provokes the first case by driving a flag-word write of 0 on the holder's port and a value read on a second port in the same cycle. It then requires that the reader sees 1 and that a later read by a third function sees 0, which shows the flag ended clear. For the simultaneous reads, the bench drives four value reads with a repeated function ID. It then checks that exactly the lowest-ID, lowest-port response returns 0.

// File: rtl/tas_lock_pkg.sv
`timescale 1ns/1ps
package tas_lock_pkg;
    // Word selected by the address code of an access
    typedef enum logic [1:0] {
        SEL_VALUE = 2'd0,
        SEL_PROBE = 2'd1,
        SEL_FID   = 2'd2,
        SEL_FLAG  = 2'd3
    } sel_e;

    // Test-and-set machine
    typedef enum logic {
        TS_OPEN = 1'b0,
        TS_HELD = 1'b1
    } ts_e;

    // Lock-state field convention inside the stored word
    localparam int          LK_ST_LSB = 0;
    localparam int          LK_ST_W   = 2;
    localparam logic [1:0]  LK_BUSY   = 2'd2;
endpackage

// File: rtl/tas_decode.sv
`timescale 1ns/1ps
module tas_decode
    import tas_lock_pkg::*;
#(
    parameter int AW      = 27,
    parameter int FW      = 2,
    parameter int FID_LSB = 25,
    parameter int SEL_LSB = 2
) (
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic          wbit0,
    output logic [FW-1:0] fid,
    output logic          rd_any,
    output logic          rd_val,
    output logic          rd_probe,
    output logic          rd_fid,
    output logic          wr_val,
    output logic          wr_rel
);
    sel_e sel;

    always_comb begin
        fid      = addr[FID_LSB +: FW];
        sel      = sel_e'(addr[SEL_LSB +: 2]);
        rd_any   = rd && !wr;
        rd_val   = rd_any && (sel == SEL_VALUE);
        rd_probe = rd_any && (sel == SEL_PROBE);
        rd_fid   = rd_any && (sel == SEL_FID);
        wr_val   = wr && (sel == SEL_VALUE);
        wr_rel   = wr && (sel == SEL_FLAG) && !wbit0;
    end
endmodule

// File: rtl/tas_pick.sv
`timescale 1ns/1ps
module tas_pick #(
    parameter int NP = 4,
    parameter int FW = 2
) (
    input  logic [NP-1:0]    req,
    input  logic [NP*FW-1:0] fid,
    output logic [NP-1:0]    grant
);
    localparam int IW = (NP > 1) ? $clog2(NP) : 1;

    logic          found;
    logic [IW-1:0] best;
    logic [FW-1:0] best_fid;

    always_comb begin
        found    = 1'b0;
        best     = '0;
        best_fid = '0;
        for (int i = 0; i < NP; i++) begin
            if (req[i] && (!found || (fid[i*FW +: FW] < best_fid))) begin
                found    = 1'b1;
                best     = IW'(i);
                best_fid = fid[i*FW +: FW];
            end
        end
        grant = '0;
        if (found) grant[best] = 1'b1;
    end
endmodule

// File: rtl/tas_core.sv
`timescale 1ns/1ps
module tas_core
    import tas_lock_pkg::*;
#(
    parameter int NP = 4,
    parameter int FW = 2,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    rd_grant,
    input  logic [NP*FW-1:0] fid,
    input  logic [NP-1:0]    wr_val,
    input  logic [NP-1:0]    wr_rel,
    input  logic [NP*DW-1:0] wdata,
    output logic             held,
    output logic             busy,
    output logic [DW-1:0]    value,
    output logic             err
);
    ts_e           st_q, st_n;
    logic [FW-1:0] holder_q, holder_n;
    logic [DW-1:0] value_q, value_n;
    logic          err_q, err_n;

    logic [NP-1:0] own, wreq;
    logic          wfound, wis_val;
    logic [DW-1:0] wd_sel;
    logic [FW-1:0] gfid;

    // Next-state process
    always_comb begin
        wreq    = wr_val | wr_rel;
        own     = '0;
        wfound  = 1'b0;
        wis_val = 1'b0;
        wd_sel  = '0;
        gfid    = '0;
        for (int i = 0; i < NP; i++) begin
            own[i] = (st_q == TS_HELD) && (fid[i*FW +: FW] == holder_q);
            if (wreq[i] && own[i] && !wfound) begin
                wfound  = 1'b1;
                wis_val = wr_val[i];
                wd_sel  = wdata[i*DW +: DW];
            end
            if (rd_grant[i]) gfid = fid[i*FW +: FW];
        end

        st_n     = st_q;
        holder_n = holder_q;
        value_n  = value_q;
        err_n    = err_q | (|(wreq & ~own));

        unique case (st_q)
            TS_OPEN: begin
                if (|rd_grant) begin          // CLAIM
                    st_n     = TS_HELD;
                    holder_n = gfid;
                end
            end
            TS_HELD: begin
                if (wfound) begin             // STORE or RELEASE
                    st_n = TS_OPEN;
                    if (wis_val) value_n = wd_sel;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= TS_OPEN;
            holder_q <= '0;
            value_q  <= '0;
            err_q    <= 1'b0;
        end else begin
            st_q     <= st_n;
            holder_q <= holder_n;
            value_q  <= value_n;
            err_q    <= err_n;
        end
    end

    // Output process
    always_comb begin
        held  = (st_q == TS_HELD);
        busy  = held || (value_q[LK_ST_LSB +: LK_ST_W] == LK_BUSY);
        value = value_q;
        err   = err_q;
    end
endmodule

// File: rtl/tas_lock_reg.sv
`timescale 1ns/1ps
module tas_lock_reg
    import tas_lock_pkg::*;
#(
    parameter int NP      = 4,
    parameter int AW      = 27,
    parameter int DW      = 16,
    parameter int FW      = 2,
    parameter int FID_LSB = 25,
    parameter int SEL_LSB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    acc_rd,
    input  logic [NP-1:0]    acc_wr,
    input  logic [NP*AW-1:0] acc_addr,
    input  logic [NP*DW-1:0] acc_wdata,
    output logic [NP-1:0]    acc_rvalid,
    output logic [NP*DW-1:0] acc_rdata,
    output logic [NP-1:0]    acc_rtas,
    output logic             acc_err
);
    logic [NP*FW-1:0] fid;
    logic [NP-1:0]    rd_any, rd_val, rd_probe, rd_fid, wr_val, wr_rel;
    logic [NP-1:0]    rd_grant;
    logic             held, busy;
    logic [DW-1:0]    value;

    for (genvar p = 0; p < NP; p++) begin : g_port
        tas_decode #(
            .AW(AW), .FW(FW), .FID_LSB(FID_LSB), .SEL_LSB(SEL_LSB)
        ) u_dec (
            .addr     (acc_addr[p*AW +: AW]),
            .rd       (acc_rd[p]),
            .wr       (acc_wr[p]),
            .wbit0    (acc_wdata[p*DW]),
            .fid      (fid[p*FW +: FW]),
            .rd_any   (rd_any[p]),
            .rd_val   (rd_val[p]),
            .rd_probe (rd_probe[p]),
            .rd_fid   (rd_fid[p]),
            .wr_val   (wr_val[p]),
            .wr_rel   (wr_rel[p])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_rvalid[p]          <= 1'b0;
                acc_rtas[p]            <= 1'b0;
                acc_rdata[p*DW +: DW]  <= '0;
            end else begin
                acc_rvalid[p] <= rd_any[p];
                acc_rtas[p]   <= rd_any[p] && (!rd_val[p] || held || !rd_grant[p]);
                if (rd_val[p])
                    acc_rdata[p*DW +: DW] <= value;
                else if (rd_probe[p])
                    acc_rdata[p*DW +: DW] <= DW'(busy);
                else if (rd_fid[p])
                    acc_rdata[p*DW +: DW] <= DW'(fid[p*FW +: FW]);
                else
                    acc_rdata[p*DW +: DW] <= '0;
            end
        end
    end

    tas_pick #(.NP(NP), .FW(FW)) u_pick (
        .req   (rd_val),
        .fid   (fid),
        .grant (rd_grant)
    );

    tas_core #(.NP(NP), .FW(FW), .DW(DW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_grant (rd_grant),
        .fid      (fid),
        .wr_val   (wr_val),
        .wr_rel   (wr_rel),
        .wdata    (acc_wdata),
        .held     (held),
        .busy     (busy),
        .value    (value),
        .err      (acc_err)
    );
endmodule

// File: rtl/tas_lock_chk.sv
`timescale 1ns/1ps
module tas_lock_chk #(
    parameter int NP = 4,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NP-1:0] acc_rd,
    input logic [NP-1:0] acc_wr,
    input logic [NP-1:0] acc_rvalid,
    input logic [NP-1:0] acc_rtas,
    input logic          acc_err,
    input logic          held,
    input logic [DW-1:0] value,
    input logic [NP-1:0] rd_val
);
    // R2
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> acc_rvalid == $past(acc_rd & ~acc_wr));

    // R3
    single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(acc_rvalid & ~acc_rtas) <= 1);

    // R2
    win_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(acc_rvalid & ~acc_rtas)) |-> held);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |=> acc_err);

    // R5
    value_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !held |=> $stable(value));

    // R4
    side_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr == '0 && rd_val == '0) |=> ($stable(value) && $stable(held)));
endmodule

bind tas_lock_reg tas_lock_chk #(.NP(NP), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_rd     (acc_rd),
    .acc_wr     (acc_wr),
    .acc_rvalid (acc_rvalid),
    .acc_rtas   (acc_rtas),
    .acc_err    (acc_err),
    .held       (held),
    .value      (value),
    .rd_val     (rd_val)
);

// File: tb/tas_lock_reg_tb.sv
`timescale 1ns/1ps
module tas_lock_reg_tb;
    localparam int NP = 4;
    localparam int AW = 27;
    localparam int DW = 16;
    localparam logic [AW-1:0] JUNK = 27'h0123450;

    typedef struct packed {
        logic [1:0]  port;
        logic [1:0]  fid;
        logic [1:0]  sel;
        logic        wr;
        logic [15:0] wd;
        logic [15:0] er;
        logic        et;
        logic        ee;
    } vec_t;

    // port fid sel wr wd er et ee
    localparam vec_t VT [14] = '{
        '{2'd0, 2'd1, 2'd0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R2 claim by fid1
        '{2'd1, 2'd2, 2'd0, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R2 flag now 1
        '{2'd2, 2'd2, 2'd1, 1'b0, 16'h0000, 16'h0001, 1'b1, 1'b0}, // R8 probe, R10
        '{2'd0, 2'd2, 2'd0, 1'b1, 16'h0009, 16'h0000, 1'b0, 1'b1}, // R6 non-holder write
        '{2'd2, 2'd3, 2'd2, 1'b0, 16'h0000, 16'h0003, 1'b1, 1'b1}, // R4 fid query
        '{2'd0, 2'd1, 2'd0, 1'b1, 16'h0006, 16'h0000, 1'b0, 1'b1}, // R5 holder store
        '{2'd0, 2'd0, 2'd0, 1'b0, 16'h0000, 16'h0006, 1'b0, 1'b1}, // R5 store cleared flag
        '{2'd3, 2'd0, 2'd3, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R7 holder release
        '{2'd3, 2'd3, 2'd1, 1'b0, 16'h0000, 16'h0001, 1'b1, 1'b1}, // R8 busy by field
        '{2'd1, 2'd2, 2'd0, 1'b0, 16'h0000, 16'h0006, 1'b0, 1'b1}, // R7 release took
        '{2'd1, 2'd2, 2'd0, 1'b1, 16'h0009, 16'h0000, 1'b0, 1'b1}, // R5 store FREE
        '{2'd2, 2'd1, 2'd1, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1}, // R8 not busy
        '{2'd0, 2'd3, 2'd0, 1'b0, 16'h0000, 16'h0009, 1'b0, 1'b1}, // R5 value kept
        '{2'd0, 2'd1, 2'd0, 1'b0, 16'h0000, 16'h0009, 1'b1, 1'b1}  // R2 second sees 1
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    acc_rd = '0, acc_wr = '0;
    logic [NP*AW-1:0] acc_addr = '0;
    logic [NP*DW-1:0] acc_wdata = '0;
    logic [NP-1:0]    acc_rvalid, acc_rtas;
    logic [NP*DW-1:0] acc_rdata;
    logic             acc_err;

    logic [NP-1:0]    s_rd, s_wr;
    logic [NP*AW-1:0] s_addr;
    logic [NP*DW-1:0] s_wd;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tas_lock_reg #(.NP(NP), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rvalid(acc_rvalid),
        .acc_rdata(acc_rdata), .acc_rtas(acc_rtas), .acc_err(acc_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic stage_clear();
        s_rd = '0; s_wr = '0; s_addr = '0; s_wd = '0;
    endtask

    task automatic stage(input int p, input logic [1:0] f, input logic [1:0] s,
                         input logic w, input logic [15:0] d);
        s_rd[p] = !w;
        s_wr[p] = w;
        s_addr[p*AW +: AW] = JUNK | (AW'(f) << 25) | (AW'(s) << 2);
        s_wd[p*DW +: DW] = d;
    endtask

    task automatic fire();
        @(negedge clk);
        acc_rd = s_rd; acc_wr = s_wr; acc_addr = s_addr; acc_wdata = s_wd;
        @(negedge clk);
        acc_rd = '0; acc_wr = '0;
    endtask

    task automatic op(input int p, input logic [1:0] f, input logic [1:0] s,
                      input logic w, input logic [15:0] d);
        stage_clear();
        stage(p, f, s, w, d);
        fire();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk("R1 rvalid", 32'(acc_rvalid), 32'h0);
        chk("R1 err", 32'(acc_err), 32'h0);

        for (int k = 0; k < 14; k++) begin
            op(int'(VT[k].port), VT[k].fid, VT[k].sel, VT[k].wr, VT[k].wd);
            if (!VT[k].wr) begin
                chk($sformatf("vec%0d rvalid", k), 32'(acc_rvalid[VT[k].port]), 32'h1);
                chk($sformatf("vec%0d rdata", k), 32'(acc_rdata[VT[k].port*DW +: DW]), 32'(VT[k].er));
                chk($sformatf("vec%0d rtas", k), 32'(acc_rtas[VT[k].port]), 32'(VT[k].et));
            end
            chk($sformatf("vec%0d err", k), 32'(acc_err), 32'(VT[k].ee));
        end

        // R1: first read after reset
        do_reset();
        op(0, 2'd0, 2'd0, 1'b0, 16'h0);
        chk("R1 rdata", 32'(acc_rdata[0 +: DW]), 32'h0);
        chk("R1 rtas", 32'(acc_rtas[0]), 32'h0);
        // R7: release writing 1 ignored, no error
        op(0, 2'd0, 2'd3, 1'b1, 16'h0001);
        chk("R7 err after wdata1", 32'(acc_err), 32'h0);
        op(1, 2'd1, 2'd0, 1'b0, 16'h0);
        chk("R7 still held", 32'(acc_rtas[1]), 32'h1);
        // R7/R6: release by non-holder
        op(2, 2'd2, 2'd3, 1'b1, 16'h0000);
        chk("R6 err non-holder release", 32'(acc_err), 32'h1);
        op(3, 2'd3, 2'd0, 1'b0, 16'h0);
        chk("R7 non-holder release ignored", 32'(acc_rtas[3]), 32'h1);

        // R6: store while OPEN
        do_reset();
        op(1, 2'd1, 2'd0, 1'b1, 16'h00A5);
        chk("R6 err store when open", 32'(acc_err), 32'h1);
        op(1, 2'd1, 2'd0, 1'b0, 16'h0);
        chk("R6 value unchanged", 32'(acc_rdata[DW +: DW]), 32'h0);
        chk("R6 flag unchanged", 32'(acc_rtas[1]), 32'h0);

        // R3: four simultaneous value reads
        do_reset();
        stage_clear();
        stage(0, 2'd3, 2'd0, 1'b0, 16'h0);
        stage(1, 2'd1, 2'd0, 1'b0, 16'h0);
        stage(2, 2'd2, 2'd0, 1'b0, 16'h0);
        stage(3, 2'd1, 2'd0, 1'b0, 16'h0);
        fire();
        chk("R3 rtas vector", 32'(acc_rtas), 32'hD);
        chk("R3 rvalid vector", 32'(acc_rvalid), 32'hF);

        // R9: holder fid1 releases while fid2 reads
        stage_clear();
        stage(1, 2'd1, 2'd3, 1'b1, 16'h0000);
        stage(2, 2'd2, 2'd0, 1'b0, 16'h0);
        fire();
        chk("R9 reader sees 1", 32'(acc_rtas[2]), 32'h1);
        op(0, 2'd3, 2'd0, 1'b0, 16'h0);
        chk("R9 flag ended clear", 32'(acc_rtas[0]), 32'h0);

        // R4: fid query from port 3 with fid 2; no side effect on flag
        op(3, 2'd2, 2'd2, 1'b0, 16'h0);
        chk("R4 fid", 32'(acc_rdata[3*DW +: DW]), 32'h2);
        chk("R10 rtas on query", 32'(acc_rtas[3]), 32'h1);
        op(2, 2'd0, 2'd1, 1'b0, 16'h0);
        chk("R8 still busy after query", 32'(acc_rdata[2*DW +: DW]), 32'h1);
        chk("R4 err untouched", 32'(acc_err), 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule